// File: doc/BRIEF.md
# Retention Scan Register Bank

A bank of single-bit state cells, each holding a main value that lives in a switchable power domain and a second, always-powered copy that doubles as the scan slave. In functional operation the bank is a plain register: a capture strobe loads the parallel data input and the parallel output shows it. For test, two non-overlapping scan strobes turn each cell into a master–slave pair. Strobe A loads the main value from the scan input, and strobe B copies it into the powered copy. The cells are chained, so the bank shifts serially from one scan input to one scan output.

The powered copy also carries state across sleep. Before the domain is switched off, a strobe B pulse saves every main value. While the domain enable is low, the main values are corrupted (unknown in simulation) and the powered copies hold. After power returns, raising the restore select and pulsing strobe A reloads every main value from its own powered copy. The scan output is taken only from the powered copy, so it stays quiet while the bank captures functional data.

This is a synchronous behavioural model. All strobes are levels sampled on one model clock, and every state change takes effect at the next rising edge.

Top module: `rsb_bank`

## Requirements
- R1: While `rst_n` is low, every main value and every powered copy is cleared, so `q_out` reads all zeros and `scan_out` reads 0.
- R2: With the domain on and both scan strobes low, a high `cap_strobe` loads `d_in` into `q_out` at the next edge. Without it, `q_out` holds whatever `d_in` does.
- R3: `scan_out` changes only on an edge where strobe B is accepted. Functional captures never move it.
- R4: With the domain on and `restore_sel` low, strobe A loads cell 0's main value from `scan_in` and cell i's main value from the powered copy of cell i-1. Cell 0 is the least significant bit of `q_out`.
- R5: With the domain on and strobe A low, strobe B copies every main value into its powered copy. `scan_out` then equals the powered copy of the most significant cell.
- R6: Strobes A and B are never high on the same edge, and `cap_strobe` is low whenever either strobe is high. Under this rule, W pairs of A then B shift a W-bit word in with its most significant bit first, and `q_out` then equals that word. During the same shift, `scan_out` presents the previous contents with the most significant bit first.
- R7: With the domain on, strobe A with `restore_sel` high reloads each main value from its own powered copy.
- R8: While `dom_pwr_en` is low, the main values and `q_out` are unknown, and no strobe alters any powered copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dom_pwr_en | input | 1 | High while the switchable domain holding the main values is powered |
| cap_strobe | input | 1 | Functional capture strobe (stands in for the system clock) |
| d_in | input | W | Parallel functional data |
| scan_in | input | 1 | Serial input to cell 0 |
| strobe_a | input | 1 | Scan master strobe; also performs the restore load |
| strobe_b | input | 1 | Scan slave strobe; also performs the pre-sleep save |
| restore_sel | input | 1 | Selects the cell's own powered copy instead of the chain input for strobe A |
| q_out | output | W | Parallel main values (unknown while the domain is off) |
| scan_out | output | 1 | Powered copy of the most significant cell |

## Verification
The hardest case to reach is a restore whose outcome proves that the powered copies were protected during sleep. The value being restored must differ from the main contents just before power-off, and stray strobes must arrive while the domain is off. The stimulus saves one pattern with strobe B and captures a different pattern. It then drops the domain enable and pulses both the capture strobe and strobe B during the outage. Only after that does it restore, so a leaking or unprotected copy would produce a word that differs from the saved one.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    // Action applied to a cell's main value on the next edge
    typedef enum logic [2:0] {
        MAIN_HOLD    = 3'd0,
        MAIN_CAPTURE = 3'd1,
        MAIN_SHIFT   = 3'd2,
        MAIN_RELOAD  = 3'd3,
        MAIN_LOST    = 3'd4
    } main_op_t;

    // Per-cell storage: switchable main bit and always-powered copy
    typedef struct packed {
        logic main_v;
        logic keep_v;
    } cell_t;

endpackage

// File: rtl/rsb_ctrl.sv
module rsb_ctrl
    import rsb_pkg::*;
(
    input  logic     pwr_on,
    input  logic     cap,
    input  logic     st_a,
    input  logic     st_b,
    input  logic     rsel,
    output main_op_t main_op,
    output logic     save_en
);

    always_comb begin
        main_op = MAIN_HOLD;
        save_en = 1'b0;
        if (!pwr_on) begin
            // Domain dark: main storage corrupts, powered copy is fenced off
            main_op = MAIN_LOST;
        end else if (st_a) begin
            main_op = rsel ? MAIN_RELOAD : MAIN_SHIFT;
        end else if (st_b) begin
            save_en = 1'b1;
        end else if (cap) begin
            main_op = MAIN_CAPTURE;
        end
    end

endmodule

// File: rtl/rsb_cell.sv
module rsb_cell
    import rsb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  main_op_t main_op,
    input  logic     save_en,
    input  logic     d,
    input  logic     si,
    output logic     q,
    output logic     so
);

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        case (main_op)
            MAIN_CAPTURE: cell_d.main_v = d;
            MAIN_SHIFT:   cell_d.main_v = si;
            MAIN_RELOAD:  cell_d.main_v = cell_q.keep_v;
            MAIN_LOST:    cell_d.main_v = 1'bx;
            default:      cell_d.main_v = cell_q.main_v;
        endcase
        if (save_en) begin
            cell_d.keep_v = cell_q.main_v;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign q  = cell_q.main_v;
    assign so = cell_q.keep_v;

endmodule

// File: rtl/rsb_bank.sv
module rsb_bank
    import rsb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dom_pwr_en,
    input  logic         cap_strobe,
    input  logic [W-1:0] d_in,
    input  logic         scan_in,
    input  logic         strobe_a,
    input  logic         strobe_b,
    input  logic         restore_sel,
    output logic [W-1:0] q_out,
    output logic         scan_out
);

    localparam int LAST = W - 1;

    main_op_t       main_op;
    logic           save_en;
    logic [W-1:0]   main_bits;
    logic [W-1:0]   keep_bits;
    logic [W-1:0]   chain_in;

    rsb_ctrl ctrl_i (
        .pwr_on  (dom_pwr_en),
        .cap     (cap_strobe),
        .st_a    (strobe_a),
        .st_b    (strobe_b),
        .rsel    (restore_sel),
        .main_op (main_op),
        .save_en (save_en)
    );

    assign chain_in[0] = scan_in;

    for (genvar gi = 0; gi < W; gi++) begin : g_cell
        if (gi > 0) begin : g_link
            assign chain_in[gi] = keep_bits[gi-1];
        end
        rsb_cell cell_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .main_op (main_op),
            .save_en (save_en),
            .d       (d_in[gi]),
            .si      (chain_in[gi]),
            .q       (main_bits[gi]),
            .so      (keep_bits[gi])
        );
    end

    assign q_out    = dom_pwr_en ? main_bits : {W{1'bx}};
    assign scan_out = keep_bits[LAST];

endmodule

// File: rtl/rsb_bank_chk.sv
module rsb_bank_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         dom_pwr_en,
    input logic         cap_strobe,
    input logic [W-1:0] d_in,
    input logic         scan_in,
    input logic         strobe_a,
    input logic         strobe_b,
    input logic         restore_sel,
    input logic [W-1:0] q_out,
    input logic         scan_out
);

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_pwr_en && cap_strobe && !strobe_a && !strobe_b) |=> (q_out == $past(d_in)));

    assert_scan_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_b |=> $stable(scan_out));

    assert_shift_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_pwr_en && strobe_a && !restore_sel) |=> (q_out[0] == $past(scan_in)));

    assert_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_pwr_en && strobe_b && !strobe_a) |=> (scan_out == $past(q_out[W-1])));

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_a && strobe_b));

    assert_cap_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_a || strobe_b) |-> !cap_strobe);

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dom_pwr_en && strobe_a && restore_sel) |=> (q_out[W-1] == $past(scan_out)));

    assert_keep_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dom_pwr_en |=> $stable(scan_out));

endmodule

bind rsb_bank rsb_bank_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .dom_pwr_en  (dom_pwr_en),
    .cap_strobe  (cap_strobe),
    .d_in        (d_in),
    .scan_in     (scan_in),
    .strobe_a    (strobe_a),
    .strobe_b    (strobe_b),
    .restore_sel (restore_sel),
    .q_out       (q_out),
    .scan_out    (scan_out)
);

// File: tb/rsb_bank_tb_top.sv
module rsb_bank_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         dom_pwr_en;
    logic         cap_strobe;
    logic [W-1:0] d_in;
    logic         scan_in;
    logic         strobe_a;
    logic         strobe_b;
    logic         restore_sel;
    logic [W-1:0] q_out;
    logic         scan_out;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    rsb_bank #(.W(W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dom_pwr_en  (dom_pwr_en),
        .cap_strobe  (cap_strobe),
        .d_in        (d_in),
        .scan_in     (scan_in),
        .strobe_a    (strobe_a),
        .strobe_b    (strobe_b),
        .restore_sel (restore_sel),
        .q_out       (q_out),
        .scan_out    (scan_out)
    );

    task automatic check_val(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Each helper raises a strobe at a falling edge and drops it at the next;
    // the rising edge in between applies it, so outputs are valid on return.
    task automatic pulse_cap(input logic [W-1:0] v);
        d_in = v; cap_strobe = 1'b1;
        @(negedge clk); cap_strobe = 1'b0;
    endtask

    task automatic pulse_a();
        strobe_a = 1'b1;
        @(negedge clk); strobe_a = 1'b0;
    endtask

    task automatic pulse_b();
        strobe_b = 1'b1;
        @(negedge clk); strobe_b = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; dom_pwr_en = 1'b1; cap_strobe = 1'b0; d_in = '0;
        scan_in = 1'b0; strobe_a = 1'b0; strobe_b = 1'b0; restore_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_val("R1 q_out after reset", q_out, '0);
        check_val("R1 scan_out after reset", {{(W-1){1'b0}}, scan_out}, '0);
    endtask

    task automatic t_capture();
        logic so0;
        so0 = scan_out;
        pulse_cap(8'h5A);
        check_val("R2 capture", q_out, 8'h5A);
        d_in = 8'hFF;
        repeat (3) @(negedge clk);
        check_val("R2 hold without strobe", q_out, 8'h5A);
        for (int k = 0; k < 4; k++) begin
            pulse_cap(8'h11 * (k + 3));
            check_val("R2 capture loop", q_out, 8'h11 * (k + 3));
            check_val("R3 scan_out quiet in capture", {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, so0});
        end
    endtask

    task automatic t_scan();
        logic [W-1:0] v = 8'hB5;
        logic [W-1:0] w = 8'h3C;
        for (int j = 0; j < W; j++) begin
            scan_in = v[W-1-j];
            pulse_a();
            check_val("R4 head loads scan_in", {{(W-1){1'b0}}, q_out[0]}, {{(W-1){1'b0}}, v[W-1-j]});
            pulse_b();
            check_val("R5 copy reaches scan_out", {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, q_out[W-1]});
        end
        check_val("R6 shifted-in word", q_out, v);
        for (int j = 0; j < W; j++) begin
            check_val("R6 shift-out order", {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, v[W-1-j]});
            scan_in = w[W-1-j];
            pulse_a();
            pulse_b();
        end
        check_val("R6 second word", q_out, w);
        scan_in = 1'b0;
    endtask

    task automatic t_retain();
        pulse_cap(8'hC3);
        pulse_b();
        check_val("R5 save before sleep", {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, 1'b1});
        pulse_cap(8'h00);
        check_val("R2 overwrite before sleep", q_out, 8'h00);
        dom_pwr_en = 1'b0;
        repeat (2) @(negedge clk);
        pulse_cap(8'hFF);
        pulse_b();
        repeat (2) @(negedge clk);
        check_val("R8 copy held while dark", {{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, 1'b1});
        dom_pwr_en = 1'b1;
        @(negedge clk);
        restore_sel = 1'b1;
        pulse_a();
        restore_sel = 1'b0;
        check_val("R7 restored word", q_out, 8'hC3);
        check_val("R8 saved word survived", q_out, 8'hC3);
    endtask

    initial begin
        t_reset();
        t_capture();
        t_scan();
        t_retain();
        t_capture();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule